// File: doc/BRIEF.md
# Opcode-Intercept Character Video Generator

This block sits between an 8-bit CPU bus and memory. It turns instruction fetches from the upper half of the address space into character video. Lines of text are kept in RAM and each line ends in a HALT opcode. Software jumps into the copy of that RAM mapped above address 0x8000. Every opcode fetch the CPU makes there is captured by the block. When the captured byte is a display code, the CPU is handed a NOP (0x00) in its place. In the refresh cycle that follows, the block redirects the memory address to a character-pattern location. That location is built from the high byte of the CPU refresh register, the six-bit character index and a small line counter. The pattern byte that comes back is registered, inverted if the code asks for it, and shifted out as pixels.

The same block also does the raster timing around those fetches:
- It raises an interrupt request while the refresh address has bit 6 low.
- It counts scan lines on every interrupt acknowledge.
- It produces a fixed-width sync pulse a fixed delay after each acknowledge.
- It combines that pulse with a vertical sync that software sets and clears through port accesses.

All bus strobes on the ports are active high, and one clock is one bus T-state.

Top module: `opcode_video_gen`

## Requirements
- R1: A fetch is intercepted when `m1`, `rd` and `addr[15]` are high and `iorq` and `halt` are low. If the fetched `mem_data[6]` is 0, `cpu_din` is 0x00 in that same cycle and the byte is captured as a display code.
- R2: In every cycle that is not an intercepted display fetch, `cpu_din` equals `mem_data`. This covers a fetch byte with bit 6 set, a fetch with `halt` high, and a fetch with `addr[15]` low. None of these cases is captured.
- R3: In the first refresh cycle (`rfsh` high) after a capture, `rom_req` is high. In that cycle `rom_addr` = (`addr` & 0xFF00) | ((code & 0x3F) << 3) | line. After that cycle the capture is consumed. Whenever `rom_req` is low, `rom_addr` equals `addr`.
- R4: The `mem_data` sampled in that refresh cycle is registered, XOR-inverted when code bit 7 was 1, and then shifted out MSB first. The shifter loads on the first `pix_ce` clock after the byte was registered, provided the shifter is empty. It moves one bit per `pix_ce` clock after that. `pixel` is 0 while the shifter is empty, and an empty shifter needs one `pix_ce` clock before it loads again.
- R5: `int_req` is high exactly in cycles where `rfsh` is high and `addr[6]` is 0.
- R6: An interrupt acknowledge (`iorq` and `m1` high together) increments the 3-bit line counter, which wraps from 7 to 0.
- R7: The timed sync is high for 20 clocks. It starts 13 clocks after the clock edge that sampled the acknowledge.
- R8: An acknowledge that arrives while a timed sync is pending or running restarts the 13-clock delay.
- R9: Any port write (`iorq` and `wr` high, `m1` low) clears the line counter.
- R10: A port read (`iorq` and `rd` high, `m1` low) with `addr[0]` = 0 sets the vertical sync. A port read with `addr[0]` = 1 leaves it unchanged. A port write clears it.
- R11: `sync` is the OR of the vertical sync and the timed sync.
- R12: After synchronous reset, `rom_req`, `pixel`, `sync` are 0, the line counter is 0, and no capture or pattern is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| m1 | input | 1 | Opcode fetch / acknowledge cycle marker |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| iorq | input | 1 | Port access / acknowledge strobe |
| rfsh | input | 1 | Refresh cycle marker |
| halt | input | 1 | CPU halted |
| addr | input | 16 | CPU address bus |
| mem_data | input | 8 | Data returned by memory |
| pix_ce | input | 1 | Pixel clock enable |
| cpu_din | output | 8 | Data presented to the CPU |
| rom_req | output | 1 | Address override active (pattern fetch) |
| rom_addr | output | 16 | Address sent to memory |
| pixel | output | 1 | Serial pixel |
| int_req | output | 1 | Line interrupt request |
| sync | output | 1 | Combined sync |

## Verification
Each internal register of this block shows up at the ports within a short, known delay:
- A stuck pending-capture flag or a wrong stored code shows up as a wrong `rom_addr` or `rom_req` in the very next refresh cycle.
- A wrong line count shows in the low three address bits of the next pattern fetch.
- A bad pattern register or shifter count shows as a wrong `pixel` within nine pixel clocks.
- A timer or vertical-sync fault changes `sync` within 33 clocks of an acknowledge or a port access.

The bench compares every output on every cycle against a behavioural model, so any of these faults is reported in the cycle where it first becomes visible.

// File: rtl/ovg_pkg.sv
package ovg_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CHAR_W = 6;

    typedef struct packed {
        logic fetch_hit;   // opcode fetch from upper mirror, not halted
        logic refresh;     // refresh cycle
        logic ack;         // interrupt acknowledge
        logic port_rd_vs;  // port read with addr[0] low
        logic port_wr;     // any port write
    } bus_ev_t;

    typedef struct packed {
        logic              inv;
        logic [CHAR_W-1:0] idx;
    } char_code_t;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_WAIT = 2'd1,
        TS_SYNC = 2'd2
    } tsync_st_e;

    function automatic logic [ADDR_W-1:0] pattern_addr(
        input logic [ADDR_W-1:0] raddr,
        input logic [CHAR_W-1:0] idx,
        input logic [7:0]        line,
        input int                line_w
    );
        logic [ADDR_W-1:0] hi, mid, lo;
        hi  = {raddr[ADDR_W-1:8], 8'h00};
        mid = ADDR_W'(idx) << line_w;
        lo  = ADDR_W'(line);
        return hi | mid | lo;
    endfunction

endpackage

// File: rtl/ovg_bus_decode.sv
module ovg_bus_decode
    import ovg_pkg::*;
(
    input  logic    m1,
    input  logic    rd,
    input  logic    wr,
    input  logic    iorq,
    input  logic    rfsh,
    input  logic    halt,
    input  logic    a15,
    input  logic    a0,
    output bus_ev_t ev
);
    always_comb begin
        ev.fetch_hit  = m1 & rd & ~iorq & ~halt & a15;
        ev.refresh    = rfsh;
        ev.ack        = m1 & iorq;
        ev.port_rd_vs = iorq & rd & ~m1 & ~a0;
        ev.port_wr    = iorq & wr & ~m1;
    end
endmodule

// File: rtl/ovg_char_fetch.sv
module ovg_char_fetch
    import ovg_pkg::*;
#(
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_hit,
    input  logic              refresh,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [LINE_W-1:0] line,
    input  logic              pat_take,
    output logic [DATA_W-1:0] cpu_din,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [DATA_W-1:0] pat_q,
    output logic              pat_new
);
    localparam int INV_BIT  = DATA_W - 1;
    localparam int SKIP_BIT = DATA_W - 2;

    char_code_t code_q;
    logic       pend_q;
    logic       capture;

    assign capture = fetch_hit & ~mem_data[SKIP_BIT];
    assign rom_req = refresh & pend_q;

    always_comb begin
        cpu_din  = capture ? '0 : mem_data;
        rom_addr = rom_req ? pattern_addr(addr, code_q.idx, 8'(line), LINE_W) : addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            code_q  <= '0;
            pat_q   <= '0;
            pat_new <= 1'b0;
        end else begin
            if (capture) begin
                pend_q      <= 1'b1;
                code_q.inv  <= mem_data[INV_BIT];
                code_q.idx  <= mem_data[CHAR_W-1:0];
            end else if (rom_req) begin
                pend_q <= 1'b0;
            end
            if (rom_req) begin
                pat_q   <= mem_data ^ {DATA_W{code_q.inv}};
                pat_new <= 1'b1;
            end else if (pat_take) begin
                pat_new <= 1'b0;
            end
        end
    end

    // R3: a pattern fetch consumes the capture
    p_pend_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (rom_req && !fetch_hit) |=> !rom_req);

    // R4: a pattern fetch always leaves a fresh byte for the shifter
    p_pat_fresh_r4: assert property (@(posedge clk) disable iff (rst)
        rom_req |=> pat_new);
endmodule

// File: rtl/ovg_pixel_shift.sv
module ovg_pixel_shift
    import ovg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_ce,
    input  logic [DATA_W-1:0] pat_byte,
    input  logic              pat_new,
    output logic              pat_take,
    output logic              pixel
);
    localparam int CW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sh_q;
    logic [CW-1:0]     left_q;

    assign pat_take = pix_ce & (left_q == '0) & pat_new;
    assign pixel    = (left_q != '0) & sh_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (pix_ce) begin
            if (left_q != '0) begin
                sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
                left_q <= left_q - 1'b1;
            end else if (pat_new) begin
                sh_q   <= pat_byte;
                left_q <= CW'(DATA_W);
            end
        end
    end

    // R4: without a pixel enable the output does not move
    p_pix_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !pix_ce |=> $stable(pixel));
endmodule

// File: rtl/ovg_sync_timer.sv
module ovg_sync_timer
    import ovg_pkg::*;
#(
    parameter int DLY = 13,
    parameter int WID = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic tsync
);
    localparam int MAXC = (DLY > WID) ? DLY : WID;
    localparam int CW   = $clog2(MAXC + 1);

    tsync_st_e     st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TS_IDLE;
            cnt_q <= '0;
        end else if (ack) begin
            st_q  <= TS_WAIT;
            cnt_q <= CW'(DLY - 1);
        end else begin
            case (st_q)
                TS_WAIT: begin
                    if (cnt_q == '0) begin
                        st_q  <= TS_SYNC;
                        cnt_q <= CW'(WID - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                TS_SYNC: begin
                    if (cnt_q == '0) st_q <= TS_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= TS_IDLE;
            endcase
        end
    end

    assign tsync = (st_q == TS_SYNC);

    // R8: an acknowledge always restarts the delay, so sync is low next cycle
    p_ack_restart_r8: assert property (@(posedge clk) disable iff (rst)
        ack |=> !tsync);

    // R7: sync only begins at the end of a delay window
    p_sync_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tsync) |-> ($past(st_q) == TS_WAIT));
endmodule

// File: rtl/opcode_video_gen.sv
module opcode_video_gen
    import ovg_pkg::*;
#(
    parameter int LINE_W   = 3,
    parameter int SYNC_DLY = 13,
    parameter int SYNC_WID = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        m1,
    input  logic        rd,
    input  logic        wr,
    input  logic        iorq,
    input  logic        rfsh,
    input  logic        halt,
    input  logic [15:0] addr,
    input  logic [7:0]  mem_data,
    input  logic        pix_ce,
    output logic [7:0]  cpu_din,
    output logic        rom_req,
    output logic [15:0] rom_addr,
    output logic        pixel,
    output logic        int_req,
    output logic        sync
);
    bus_ev_t           ev;
    logic [LINE_W-1:0] line_q;
    logic              vsync_q;
    logic              tsync;
    logic [DATA_W-1:0] pat_q;
    logic              pat_new;
    logic              pat_take;

    ovg_bus_decode u_dec (
        .m1   (m1),
        .rd   (rd),
        .wr   (wr),
        .iorq (iorq),
        .rfsh (rfsh),
        .halt (halt),
        .a15  (addr[15]),
        .a0   (addr[0]),
        .ev   (ev)
    );

    ovg_char_fetch #(.LINE_W(LINE_W)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .fetch_hit (ev.fetch_hit),
        .refresh   (ev.refresh),
        .addr      (addr),
        .mem_data  (mem_data),
        .line      (line_q),
        .pat_take  (pat_take),
        .cpu_din   (cpu_din),
        .rom_req   (rom_req),
        .rom_addr  (rom_addr),
        .pat_q     (pat_q),
        .pat_new   (pat_new)
    );

    ovg_pixel_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .pix_ce   (pix_ce),
        .pat_byte (pat_q),
        .pat_new  (pat_new),
        .pat_take (pat_take),
        .pixel    (pixel)
    );

    ovg_sync_timer #(.DLY(SYNC_DLY), .WID(SYNC_WID)) u_tsync (
        .clk   (clk),
        .rst   (rst),
        .ack   (ev.ack),
        .tsync (tsync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= '0;
            vsync_q <= 1'b0;
        end else begin
            if (ev.ack)          line_q <= line_q + 1'b1;
            else if (ev.port_wr) line_q <= '0;
            if (ev.port_wr)         vsync_q <= 1'b0;
            else if (ev.port_rd_vs) vsync_q <= 1'b1;
        end
    end

    assign int_req = addr[6] ? 1'b0 : ev.refresh;
    assign sync    = vsync_q | tsync;

    // R6: line counter steps by one on acknowledge
    p_line_step_r6: assert property (@(posedge clk) disable iff (rst)
        ev.ack |=> (line_q == LINE_W'($past(line_q) + 1'b1)));

    // R9: port write clears the line counter
    p_line_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ev.port_wr && !ev.ack) |=> (line_q == '0));

    // R10: qualifying port read raises vertical sync
    p_vsync_on_r10: assert property (@(posedge clk) disable iff (rst)
        (ev.port_rd_vs && !ev.port_wr) |=> vsync_q);

    // R11: combined sync is high whenever the vertical sync is held
    p_sync_or_r11: assert property (@(posedge clk) disable iff (rst)
        vsync_q |-> sync);
endmodule

// File: tb/test_opcode_video_gen.sv
module test_opcode_video_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m1 = 0, rd = 0, wr = 0, iorq = 0, rfsh = 0, halt = 0, pix_ce = 1;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  mem_data = 8'h00;
    logic [7:0]  cpu_din;
    logic        rom_req, pixel, int_req, sync;
    logic [15:0] rom_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit gap_mode = 0;

    always #5 clk = ~clk;

    opcode_video_gen i_opcode_video_gen (
        .clk(clk), .rst(rst), .m1(m1), .rd(rd), .wr(wr), .iorq(iorq),
        .rfsh(rfsh), .halt(halt), .addr(addr), .mem_data(mem_data),
        .pix_ce(pix_ce), .cpu_din(cpu_din), .rom_req(rom_req),
        .rom_addr(rom_addr), .pixel(pixel), .int_req(int_req), .sync(sync)
    );

    // behavioural reference state
    bit       m_pend, m_new, m_vs, have_ack;
    bit [7:0] m_code, m_pat;
    int       m_line;
    longint   cyc, last_ack;
    bit       bits_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_new = 0; m_vs = 0; have_ack = 0;
            m_code = 0; m_pat = 0; m_line = 0;
            bits_q.delete();
        end else begin
            if (pix_ce) begin
                if (bits_q.size() > 0) void'(bits_q.pop_front());
                else if (m_new) begin
                    for (int i = 7; i >= 0; i--) bits_q.push_back(m_pat[i]);
                    m_new = 0;
                end
            end
            if (rfsh && m_pend) begin
                m_pat  = mem_data ^ {8{m_code[7]}};
                m_new  = 1;
                m_pend = 0;
            end
            if (m1 && rd && !iorq && !halt && addr[15] && !mem_data[6]) begin
                m_pend = 1;
                m_code = mem_data;
            end
            if (m1 && iorq) m_line = (m_line + 1) % 8;
            else if (iorq && wr && !m1) m_line = 0;
            if (iorq && wr && !m1) m_vs = 0;
            else if (iorq && rd && !m1 && !addr[0]) m_vs = 1;
            if (m1 && iorq) begin have_ack = 1; last_ack = cyc; end
        end
        cyc++;
    end

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always begin
        @(negedge clk);
        #3;
        if (!rst && !done) begin
            logic [7:0]  e_din;
            logic        e_req, e_pix, e_int, e_sync;
            logic [15:0] e_addr;
            e_din  = (m1 && rd && !iorq && !halt && addr[15] && !mem_data[6]) ? 8'h00 : mem_data;
            e_req  = rfsh && m_pend;
            e_addr = e_req ? (({addr[15:8], 8'h00}) | (16'(m_code[5:0]) << 3) | 16'(m_line)) : addr;
            e_pix  = (bits_q.size() > 0) ? bits_q[0] : 1'b0;
            e_int  = rfsh && !addr[6];
            e_sync = m_vs || (have_ack && (cyc - last_ack) >= 14 && (cyc - last_ack) <= 33);
            chk("R1 R2", "cpu_din", 16'(cpu_din), 16'(e_din));
            chk("R3 R6 R9", "rom_req", 16'(rom_req), 16'(e_req));
            chk("R3 R6 R9", "rom_addr", rom_addr, e_addr);
            chk("R4", "pixel", 16'(pixel), 16'(e_pix));
            chk("R5", "int_req", 16'(int_req), 16'(e_int));
            chk("R7 R8 R10 R11", "sync", 16'(sync), 16'(e_sync));
        end
    end

    task automatic bus_clear();
        m1 = 0; rd = 0; wr = 0; iorq = 0; rfsh = 0; halt = 0;
        pix_ce = gap_mode ? ~pix_ce : 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bus_clear(); addr = 16'h0040; mem_data = 8'h00;
        end
    endtask

    task automatic fetch(logic [15:0] a, logic [7:0] d, logic h);
        @(negedge clk); bus_clear(); m1 = 1; rd = 1; halt = h; addr = a; mem_data = d;
    endtask

    task automatic refresh(logic [15:0] a, logic [7:0] d);
        @(negedge clk); bus_clear(); rfsh = 1; addr = a; mem_data = d;
    endtask

    task automatic ack();
        @(negedge clk); bus_clear(); m1 = 1; iorq = 1; addr = 16'h0040; mem_data = 8'hFF;
    endtask

    task automatic port_rd(logic [15:0] a);
        @(negedge clk); bus_clear(); iorq = 1; rd = 1; addr = a; mem_data = 8'h5A;
    endtask

    task automatic port_wr(logic [15:0] a);
        @(negedge clk); bus_clear(); iorq = 1; wr = 1; addr = a; mem_data = 8'h00;
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 0; bus_clear();
        #3;
        // R12: reset state at the ports
        chk("R12", "rom_req after reset", 16'(rom_req), 16'h0);
        chk("R12", "pixel after reset", 16'(pixel), 16'h0);
        chk("R12", "sync after reset", 16'(sync), 16'h0);

        // R1 R3 R4: display characters, plain and inverted
        fetch(16'hC000, 8'h05, 0); refresh(16'h2080, 8'hB2); idle(10);
        fetch(16'hC001, 8'h85, 0); refresh(16'h21C1, 8'h3C); idle(10);
        fetch(16'hC002, 8'hBF, 0); refresh(16'h3F02, 8'h81); idle(2);
        fetch(16'hC003, 8'h01, 0); refresh(16'h3F03, 8'hF0); idle(12);

        // R2: pass-through cases, no capture afterwards
        fetch(16'hC010, 8'h45, 0); refresh(16'h2010, 8'h11);
        fetch(16'hC011, 8'h76, 1); refresh(16'h2011, 8'h22);
        fetch(16'h4012, 8'h07, 0); refresh(16'h2012, 8'h33);
        idle(3);

        // R6: acknowledges step and wrap the line counter
        for (int k = 0; k < 9; k++) begin
            ack(); fetch(16'hC020, 8'h0A, 0); refresh(16'h1400, 8'h5A); idle(2);
        end
        idle(40);

        // R7 R8: timed sync and restart
        ack(); idle(40);
        ack(); idle(5); ack(); idle(40);
        ack(); idle(20); ack(); idle(40);

        // R9 R10 R11: programmatic sync and line clear
        port_rd(16'h00FE); idle(3);
        fetch(16'hC030, 8'h03, 0); refresh(16'h0800, 8'h0F); idle(2);
        port_wr(16'h00FF); idle(2);
        fetch(16'hC031, 8'h03, 0); refresh(16'h0800, 8'h0F); idle(2);
        port_rd(16'h00FF); idle(3);
        port_rd(16'h00FE); ack(); idle(40);
        port_wr(16'h00FE); idle(40);

        // R4: pixel enable gaps
        gap_mode = 1;
        fetch(16'hC040, 8'h2A, 0); refresh(16'h2040, 8'hC3); idle(25);
        fetch(16'hC041, 8'hAA, 0); refresh(16'h2041, 8'h96); idle(25);
        gap_mode = 0;

        // mixed traffic
        for (int n = 0; n < 2000; n++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: fetch({1'b1, 15'($urandom)}, 8'($urandom), 1'($urandom_range(0, 5) == 0));
                3, 4:    refresh(16'($urandom), 8'($urandom));
                5:       if ($urandom_range(0, 3) == 0) ack(); else idle(1);
                6:       if ($urandom_range(0, 7) == 0) port_rd(16'($urandom)); else idle(1);
                7:       if ($urandom_range(0, 15) == 0) port_wr(16'($urandom)); else idle(1);
                default: fetch(16'($urandom), 8'($urandom), 0);
            endcase
            gap_mode = ($urandom_range(0, 3) == 0);
        end
        gap_mode = 0;
        idle(40);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule